// File: doc/BRIEF.md
# Clock Source Selector with Fractional Rate Divider

This block picks one clock-enable stream out of a bank of up to sixteen and thins it by a programmable fixed-point ratio. The result is a single clock-enable pulse stream for a downstream consumer. Every input and output is a one-cycle enable pulse in a single clock domain. A phase accumulator turns the ratio into pulses, so a divide-by-2.5 gives five output pulses for every twelve and a half source pulses, spread as evenly as whole pulses allow.

Two words written from outside program it. The control word carries the source select, an enable and a read-only busy flag. The divider word holds an integer part whose least significant bit is fixed at bit 12, with a fraction of configurable width directly below it. The integer and fraction widths are instance parameters. When both are zero the instance has no divider and forwards the selected source unchanged.

Top module: `clk_src_frac_div`

## Requirements
- R1: `clk_en_out` never pulses while the enable bit (control bit 4) is clear.
- R2: The busy flag (control bit 7) reads back the enable bit from the most recent control write. Writes to bit 7 itself are ignored.
- R3: Control bits [3:0] select the source. Index 0 is tied to ground and never produces an output pulse, whatever `src_en[0]` does.
- R4: The divisor is divider-word bits [12+INT_BITS-1 : 12-FRAC_BITS]. Other bits are discarded and read back as zero.
- R5: A divisor of zero keeps `clk_en_out` low.
- R6: Each selected source pulse adds 2^FRAC_BITS to an accumulator. When the sum reaches the divisor, the block emits one output pulse one cycle later and subtracts the divisor. Starting from a cleared accumulator with divisor d ≥ 2^FRAC_BITS, N source pulses give floor(N·2^FRAC_BITS/d) output pulses.
- R7: Pulses on sources other than the selected one have no effect on the output.
- R8: An instance with zero integer and zero fraction bits echoes each selected, enabled source pulse one cycle later.
- R9: Any write to either word clears the accumulator, and the output is low in the cycle after the write.
- R10: A divisor below 2^FRAC_BITS (ratio under one) gives exactly one output pulse per selected source pulse.
- R11: After reset, both read words are zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | NUM_SRC | Clock-enable pulse per source |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control write data: [3:0] select, [4] enable |
| div_wr | input | 1 | Divider word write strobe |
| div_wdata | input | 32 | Divider write data, divisor field ending at bit 12 |
| ctl_rdata | output | 8 | Control read: [3:0] select, [4] enable, [7] busy |
| div_rdata | output | 32 | Divider read: divisor field in place, other bits zero |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
The bench targets the divisor edges: zero, the largest field value, exactly one, a ratio below one, and a non-integer ratio. A wrong field offset or a missing accumulator remainder shows up as a wrong pulse count over a long run. A ratio below one tests the remainder clamp; without it the accumulator would grow until it wrapped. The bench also checks that a write in mid-run drops a half-filled phase, which a design without the clear would turn into an early pulse. It checks that ground and unselected sources stay silent under heavy toggling. It drives a pass-through twin alongside, which would show any stray divider logic.

// File: rtl/csfd_pkg.sv
// Package: shared field positions for the clock source selector and
// fractional divider. Assumes an 8-bit control word and a 32-bit divider word.
package csfd_pkg;
    localparam int CTL_W      = 8;
    localparam int SEL_W      = 4;
    localparam int SEL_LSB    = 0;
    localparam int EN_BIT     = 4;
    localparam int BUSY_BIT   = 7;
    localparam int DIVW_W     = 32;
    localparam int INT_ANCHOR = 12;
    localparam int MAX_SRC    = 16;
endpackage

// File: rtl/csfd_src_sel.sv
// Module: picks one clock-enable line by index. Index 0 is ground, and indices
// at or above NUM_SRC also read as ground. Assumes NUM_SRC <= 16.
module csfd_src_sel
    import csfd_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   sel,
    output logic               pulse
);
    logic [NUM_SRC-1:0] masked;

    // Tie index 0 low; forward the other lines as they are.
    assign masked[0] = src_en[0] & 1'b0;
    generate
        for (genvar g = 1; g < NUM_SRC; g++) begin : g_pass
            assign masked[g] = src_en[g];
        end
    endgenerate

    // One-hot compare against the select field.
    always_comb begin
        pulse = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) pulse = masked[i];
        end
    end
endmodule

// File: rtl/csfd_phase_acc.sv
// Module: fixed-point phase accumulator. Each adv pulse adds 2^FRAC_BITS.
// Reaching the divisor emits one registered pulse and subtracts it. The
// remainder is clamped below the divisor, so a ratio under one gives one pulse
// per advance. A zero divisor holds everything still. Assumes clr arrives
// together with any divisor change.
module csfd_phase_acc #(
    parameter int DIV_W     = 8,
    parameter int FRAC_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             pulse
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] STEP = {{(ACC_W-1){1'b0}}, 1'b1} << FRAC_BITS;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] divx;
    logic [ACC_W-1:0] rem;
    logic [ACC_W-1:0] rem_c;
    logic             hit;
    logic             div_nz;

    // Next-phase arithmetic: add one step, test and subtract the divisor.
    always_comb begin
        divx   = {1'b0, div};
        div_nz = (div != '0);
        sum    = acc_q + STEP;
        hit    = (sum >= divx);
        rem    = sum - divx;
        rem_c  = (rem >= divx) ? (divx - 1'b1) : rem;
    end

    // Phase register and output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (adv && div_nz) begin
            pulse <= hit;
            acc_q <= hit ? rem_c : sum;
        end else begin
            pulse <= 1'b0;
        end
    end

    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !pulse); // R5
    AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0) |-> (acc_q < {1'b0, div})); // R6
    AST_ONE_PER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> !pulse); // R10
endmodule

// File: rtl/clk_src_frac_div.sv
// Module: clock-enable source selector with fractional divider (top).
// Holds the control and divider words and picks the source. Either divides it
// with the phase accumulator or, when INT_BITS and FRAC_BITS are both zero,
// forwards it. Assumes INT_BITS <= 12, FRAC_BITS <= 12, NUM_SRC <= 16.
module clk_src_frac_div
    import csfd_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               div_wr,
    input  logic [DIVW_W-1:0]  div_wdata,
    output logic [CTL_W-1:0]   ctl_rdata,
    output logic [DIVW_W-1:0]  div_rdata,
    output logic               clk_en_out
);
    localparam int  DIV_W     = INT_BITS + FRAC_BITS;
    localparam int  FIELD_LSB = INT_ANCHOR - FRAC_BITS;
    localparam bit  PASS      = (DIV_W == 0);

    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    logic             busy_q;
    logic             sel_pulse;
    logic             wr_any;
    logic             adv;

    // Control word storage; busy is captured from the written enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            en_q   <= 1'b0;
            busy_q <= 1'b0;
        end else if (ctl_wr) begin
            sel_q  <= ctl_wdata[SEL_LSB +: SEL_W];
            en_q   <= ctl_wdata[EN_BIT];
            busy_q <= ctl_wdata[EN_BIT];
        end
    end

    // Control read-back with reserved bits as zero.
    always_comb begin
        ctl_rdata                     = '0;
        ctl_rdata[SEL_LSB +: SEL_W]   = sel_q;
        ctl_rdata[EN_BIT]             = en_q;
        ctl_rdata[BUSY_BIT]           = busy_q;
    end

    csfd_src_sel #(.NUM_SRC(NUM_SRC)) i_src_sel (
        .src_en (src_en),
        .sel    (sel_q),
        .pulse  (sel_pulse)
    );

    assign wr_any = ctl_wr | div_wr;
    assign adv    = en_q & sel_pulse & ~wr_any;

    generate
        if (PASS) begin : g_pass
            logic out_q;

            // Forward the selected enable one cycle later.
            always_ff @(posedge clk) begin
                if (!rst_n) out_q <= 1'b0;
                else        out_q <= adv;
            end

            assign clk_en_out = out_q;
            assign div_rdata  = '0;

            AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                adv |=> clk_en_out); // R8
        end else begin : g_div
            logic [DIV_W-1:0] div_q;

            // Divider word storage: keep only the divisor field.
            always_ff @(posedge clk) begin
                if (!rst_n)      div_q <= '0;
                else if (div_wr) div_q <= div_wdata[FIELD_LSB +: DIV_W];
            end

            assign div_rdata = {{(DIVW_W-DIV_W){1'b0}}, div_q} << FIELD_LSB;

            csfd_phase_acc #(.DIV_W(DIV_W), .FRAC_BITS(FRAC_BITS)) i_phase_acc (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (wr_any),
                .adv   (adv),
                .div   (div_q),
                .pulse (clk_en_out)
            );
        end
    endgenerate

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !clk_en_out); // R1
    AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata[BUSY_BIT] == $past(ctl_wdata[EN_BIT]))); // R2
    AST_GROUND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |=> !clk_en_out); // R3
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> !clk_en_out); // R9
endmodule

// File: tb/test_clk_src_frac_div.sv
// Bench: a behavioural model checked against two instances on every cycle, one
// dividing (4.4 format) and one pass-through, plus pulse-count checks.
module test_clk_src_frac_div;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 16;
    localparam int IB    = 4;
    localparam int FB    = 4;
    localparam int STEP  = 1 << FB;
    localparam int SHIFT = 12 - FB;
    localparam int MASK  = (1 << (IB + FB)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_en = '0;
    logic            ctl_wr = 1'b0;
    logic [7:0]      ctl_wdata = '0;
    logic            div_wr = 1'b0;
    logic [31:0]     div_wdata = '0;
    logic [7:0]      ctl_rdata, ctl_rdata_pt;
    logic [31:0]     div_rdata, div_rdata_pt;
    logic            out_d, out_pt;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_frac_div #(.NUM_SRC(NSRC), .INT_BITS(IB), .FRAC_BITS(FB)) i_clk_src_frac_div (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata), .ctl_rdata(ctl_rdata),
        .div_rdata(div_rdata), .clk_en_out(out_d));

    clk_src_frac_div #(.NUM_SRC(NSRC), .INT_BITS(0), .FRAC_BITS(0)) i_clk_src_frac_div_pt (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata), .ctl_rdata(ctl_rdata_pt),
        .div_rdata(div_rdata_pt), .clk_en_out(out_pt));

    int n_cmp = 0;
    int n_bad = 0;
    int out_cnt = 0;
    int pt_cnt = 0;
    bit done = 0;
    string cur_req = "R11";

    // Reference model state.
    int m_sel = 0, m_en = 0, m_busy = 0, m_div = 0, m_acc = 0, m_out = 0, m_pt = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model: advance on each rising edge from the inputs held stable since the falling edge.
    always @(posedge clk) begin
        int p, s, n_out, n_pt;
        if (!rst_n) begin
            m_sel = 0; m_en = 0; m_busy = 0; m_div = 0; m_acc = 0; m_out = 0; m_pt = 0;
        end else begin
            p = (m_sel != 0) ? int'(src_en[m_sel]) : 0;
            n_out = 0; n_pt = 0;
            if (!(ctl_wr || div_wr) && m_en != 0 && p != 0) begin
                n_pt = 1;
                if (m_div != 0) begin
                    s = m_acc + STEP;
                    if (s >= m_div) begin
                        n_out = 1;
                        m_acc = s - m_div;
                        if (m_acc >= m_div) m_acc = m_div - 1;
                    end else m_acc = s;
                end
            end
            if (ctl_wr || div_wr) m_acc = 0;
            if (ctl_wr) begin
                m_sel = int'(ctl_wdata[3:0]); m_en = int'(ctl_wdata[4]); m_busy = int'(ctl_wdata[4]);
            end
            if (div_wr) m_div = int'((div_wdata >> SHIFT) & MASK);
            m_out = n_out; m_pt = n_pt;
        end
    end

    // Compare every cycle at the falling edge and count output pulses.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "clk_en_out", out_d, m_out);
            check("R8", "pass-through out", out_pt, m_pt);
            check("R2", "ctl_rdata", ctl_rdata, {m_busy[0], 2'b00, m_en[0], m_sel[3:0]});
            check("R4", "div_rdata", div_rdata, 32'(m_div) << SHIFT);
            check("R8", "pass-through div_rdata", div_rdata_pt, 0);
            if (out_d)  out_cnt++;
            if (out_pt) pt_cnt++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_ctl(input int sel, input int en);
        ctl_wr = 1'b1;
        ctl_wdata = {1'b0, 2'b00, en[0], sel[3:0]};
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [31:0] word);
        div_wr = 1'b1;
        div_wdata = word;
        tick();
        div_wr = 1'b0;
    endtask

    // mode 0: random, 1: all lines high, 2: selected line held low, others random.
    task automatic run_src(input int n, input int sel, input int mode, output int npulse, output int nout, output int npt);
        int o0 = out_cnt;
        int p0 = pt_cnt;
        npulse = 0;
        for (int i = 0; i < n; i++) begin
            logic [NSRC-1:0] v = NSRC'($urandom);
            if (mode == 1) v = '1;
            if (mode == 2) v[sel] = 1'b0;
            if (v[sel]) npulse++;
            src_en = v;
            tick();
        end
        src_en = '0;
        tick();
        nout = out_cnt - o0;
        npt = pt_cnt - p0;
    endtask

    initial begin
        int np, no, npt;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R11", "reset ctl_rdata", ctl_rdata, 0);
        check("R11", "reset div_rdata", div_rdata, 0);
        check("R11", "reset out", out_d, 0);

        cur_req = "R3";
        wr_ctl(0, 1); wr_div(32'd16 << SHIFT);
        run_src(40, 0, 1, np, no, npt);
        check("R3", "ground source pulses", no, 0);
        check("R3", "ground pass-through pulses", npt, 0);

        cur_req = "R1";
        wr_ctl(5, 0);
        check("R2", "busy while disabled", ctl_rdata[7], 0);
        run_src(40, 5, 1, np, no, npt);
        check("R1", "disabled pulses", no, 0);
        ctl_wr = 1'b1; ctl_wdata = 8'h95; tick(); ctl_wr = 1'b0;
        check("R2", "busy after enable, bit7 write ignored", ctl_rdata, 8'h95);

        cur_req = "R6";
        wr_div(32'd40 << SHIFT);
        run_src(300, 5, 0, np, no, npt);
        check("R6", "ratio 2.5 count", no, (np * STEP) / 40);
        check("R8", "pass-through count", npt, np);

        wr_ctl(9, 1); wr_div(32'd48 << SHIFT);
        run_src(300, 9, 0, np, no, npt);
        check("R6", "ratio 3.0 count", no, (np * STEP) / 48);

        wr_ctl(2, 1); wr_div(32'd255 << SHIFT);
        run_src(400, 2, 1, np, no, npt);
        check("R6", "max divisor count", no, (np * STEP) / 255);

        cur_req = "R4";
        wr_div((32'd32 << SHIFT) | 32'hFFFF_00FF);
        run_src(200, 2, 0, np, no, npt);
        check("R4", "field with junk bits, ratio 2.0", no, (np * STEP) / 32);
        check("R4", "field read-back", div_rdata, 32'd32 << SHIFT);

        cur_req = "R5";
        wr_div(32'h0000_00FF);
        run_src(100, 2, 1, np, no, npt);
        check("R5", "zero divisor pulses", no, 0);

        cur_req = "R10";
        wr_div(32'd8 << SHIFT);
        run_src(200, 2, 0, np, no, npt);
        check("R10", "ratio 0.5 count", no, np);

        cur_req = "R7";
        wr_ctl(3, 1); wr_div(32'd16 << SHIFT);
        run_src(200, 3, 2, np, no, npt);
        check("R7", "unselected sources pulses", no, 0);
        check("R7", "unselected pass-through pulses", npt, 0);

        cur_req = "R9";
        wr_div(32'd48 << SHIFT);
        src_en = '1; tick(); tick(); src_en = '0;
        wr_ctl(3, 1);
        run_src(2, 3, 1, np, no, npt);
        check("R9", "cleared phase after write", no, 0);
        run_src(1, 3, 1, np, no, npt);
        check("R9", "third pulse reaches divisor", no, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule